// File: doc/BRIEF.md
# Flash Self-Programming Address Unit

This block connects a processor core to a program flash that is organised in 16-bit words. Software forms a 16-bit byte pointer from two 8-bit registers, a high half and a low half. The block decodes that one pointer in two ways.

For programming, the pointer always names a whole aligned word, and bit 0 is never looked at. A fill command places one 16-bit word into a page-sized staging buffer. The slot is chosen by the pointer bits between bit 1 and the page boundary. A commit command then copies the whole buffer, one word per cycle, into the flash page named by the pointer bits above the page boundary. Any offset bits present in the pointer during a commit are disregarded.

For reading, bit 0 does take part in decoding. A read command fetches the word whose word address is the pointer shifted right by one, and returns the low or the high byte of it. The flash array sits outside the block. It is driven through a synchronous write port and a synchronous read port, and each port has one cycle of latency.

Top module: `prog_addr_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, busy, commit_done, rd_valid, fl_we and fl_re are all 0.
- R2: A read accepted when idle drives fl_re with fl_raddr equal to pointer[15:1], so a word address maps to the pointer value that word address times 2 produces. In the next cycle rd_valid is 1 and rd_byte holds bits [7:0] of that flash word when pointer bit 0 is 0, or bits [15:8] when it is 1.
- R3: A fill accepted when idle stores fill_data into buffer slot pointer[log2(PAGE_BYTES)-1:1]. Pointer bit 0 and the page bits have no effect on the slot, so an odd pointer writes the same slot as the even value just below it.
- R4: A commit accepted when idle writes all PAGE_BYTES/2 buffer slots to flash on consecutive cycles, in increasing slot order, starting the cycle after acceptance. fl_waddr is {pointer[15:log2(PAGE_BYTES)], slot}, and the offset bits of the pointer are ignored.
- R5: busy is 1 for exactly PAGE_BYTES/2 consecutive cycles, starting the cycle after a commit is accepted.
- R6: commit_done is 1 for exactly one cycle, the first cycle in which busy is 0 again.
- R7: While busy is 1, fill, read and commit commands are ignored: there is no buffer change, no rd_valid, no flash write outside the running page, and the busy period is not lengthened.
- R8: When several commands arrive in the same idle cycle, commit takes priority over fill, and fill takes priority over read. The commands that lose are ignored.
- R9: Every buffer slot resets to 0xFFFF. Slots keep their contents across a commit, so a later commit writes the same data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_hi | input | 8 | High byte of the byte pointer |
| ptr_lo | input | 8 | Low byte of the byte pointer |
| cmd_fill | input | 1 | Store fill_data into the page buffer |
| fill_data | input | 16 | Word for the page buffer |
| cmd_commit | input | 1 | Copy the page buffer to the flash page |
| cmd_read | input | 1 | Read one byte of program memory |
| rd_byte | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | rd_byte is valid this cycle |
| busy | output | 1 | Page copy in progress |
| commit_done | output | 1 | One-cycle pulse at the end of a page copy |
| fl_we | output | 1 | Flash word write enable |
| fl_waddr | output | 15 | Flash word write address |
| fl_wdata | output | 16 | Flash word write data |
| fl_re | output | 1 | Flash word read enable |
| fl_raddr | output | 15 | Flash word read address |
| fl_rdata | input | 16 | Flash read data, one cycle after fl_re |

## Verification
The assertions check the following on every cycle:
- the length of the busy window and where the done pulse falls relative to it;
- that the write addresses step one word at a time from slot 0 within a single page;
- that no flash read is issued while busy;
- that every read enable is followed by exactly one valid strobe.

Some behaviour cannot be seen by a cycle-level property, and only the bench's scenarios show it:
- which buffer slot an odd or page-polluted pointer reaches;
- which byte of a word is returned;
- that a losing or busy-time fill leaves the buffer untouched;
- that the buffer survives a commit.

The bench demonstrates these by reading data back from its flash model.

// File: rtl/prog_addr_pkg.sv
`timescale 1ns/1ps
package prog_addr_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_COPY = 1'b1
   } seq_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ptr_decode.sv
`timescale 1ns/1ps
module ptr_decode #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned PAGE_BYTES = 64,
   localparam int unsigned PTR_W     = 2 * REG_W,
   localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
   localparam int unsigned SLOT_W    = OFF_W - 1,
   localparam int unsigned PAGE_W    = PTR_W - OFF_W,
   localparam int unsigned FADDR_W   = PTR_W - 1
) (
   input  logic [REG_W-1:0]   ptr_hi,
   input  logic [REG_W-1:0]   ptr_lo,
   output logic [FADDR_W-1:0] word_addr,
   output logic [PAGE_W-1:0]  page_num,
   output logic [SLOT_W-1:0]  slot,
   output logic               byte_sel
);

   // Word address: the pointer without its byte-select bit.
   assign word_addr = {ptr_hi, ptr_lo[REG_W-1:1]};
   assign byte_sel  = ptr_lo[0];
   // Slot inside the page: offset bits above bit 0.
   assign slot      = ptr_lo[OFF_W-1:1];

   generate
      if (OFF_W == REG_W) begin : g_page_in_hi
         // Largest page: the page number is exactly the high register.
         assign page_num = ptr_hi;
      end else begin : g_page_split
         // Smaller pages: upper low-register bits extend the page number.
         assign page_num = {ptr_hi, ptr_lo[REG_W-1:OFF_W]};
      end
   endgenerate

endmodule

// File: rtl/page_buffer.sv
`timescale 1ns/1ps
module page_buffer #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned SLOTS   = 32,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [WORD_W-1:0] rd_data
);

   localparam logic [WORD_W-1:0] ERASED = '1;

   logic [WORD_W-1:0] slot_q [SLOTS];

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         logic hit;
         assign hit = wr_en && (wr_slot == SLOT_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[i] <= ERASED;
            end else if (hit) begin
               slot_q[i] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/commit_seq.sv
`timescale 1ns/1ps
module commit_seq
   import prog_addr_pkg::*;
#(
   parameter int unsigned PAGE_W   = 10,
   parameter int unsigned SLOT_W   = 5,
   localparam int unsigned FADDR_W = PAGE_W + SLOT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PAGE_W-1:0]  start_page,
   output logic               busy,
   output logic               done,
   output logic               fl_we,
   output logic [FADDR_W-1:0] fl_waddr,
   output logic [SLOT_W-1:0]  cur_slot
);

   seq_state_e        state_q;
   logic [PAGE_W-1:0] page_q;
   logic [SLOT_W-1:0] idx_q;
   logic              done_q;
   logic              last_slot;

   assign last_slot = &idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         page_q  <= '0;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_COPY;
                  page_q  <= start_page;
                  idx_q   <= '0;
               end
            end
            SEQ_COPY: begin
               idx_q <= idx_q + 1'b1;
               if (last_slot) begin
                  state_q <= SEQ_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == SEQ_COPY);
   assign done     = done_q;
   assign fl_we    = busy;
   assign fl_waddr = {page_q, idx_q};
   assign cur_slot = idx_q;

endmodule

// File: rtl/byte_reader.sv
`timescale 1ns/1ps
module byte_reader #(
   parameter int unsigned REG_W    = 8,
   localparam int unsigned WORD_W  = 2 * REG_W,
   localparam int unsigned FADDR_W = 2 * REG_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [FADDR_W-1:0] word_addr,
   input  logic               byte_sel,
   output logic               fl_re,
   output logic [FADDR_W-1:0] fl_raddr,
   input  logic [WORD_W-1:0]  fl_rdata,
   output logic [REG_W-1:0]   rd_byte,
   output logic               rd_valid
);

   logic valid_q;
   logic sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         sel_q   <= 1'b0;
      end else begin
         valid_q <= accept;
         if (accept) begin
            sel_q <= byte_sel;
         end
      end
   end

   assign fl_re    = accept;
   assign fl_raddr = word_addr;
   assign rd_valid = valid_q;

   always_comb begin
      rd_byte = '0;
      if (valid_q) begin
         rd_byte = sel_q ? fl_rdata[WORD_W-1:REG_W] : fl_rdata[REG_W-1:0];
      end
   end

endmodule

// File: rtl/prog_addr_unit.sv
`timescale 1ns/1ps
module prog_addr_unit
   import prog_addr_pkg::*;
#(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned PAGE_BYTES = 64,
   localparam int unsigned PTR_W     = 2 * REG_W,
   localparam int unsigned WORD_W    = 2 * REG_W,
   localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
   localparam int unsigned SLOT_W    = OFF_W - 1,
   localparam int unsigned SLOTS     = PAGE_BYTES / 2,
   localparam int unsigned PAGE_W    = PTR_W - OFF_W,
   localparam int unsigned FADDR_W   = PTR_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_W-1:0]   ptr_hi,
   input  logic [REG_W-1:0]   ptr_lo,
   input  logic               cmd_fill,
   input  logic [WORD_W-1:0]  fill_data,
   input  logic               cmd_commit,
   input  logic               cmd_read,
   output logic [REG_W-1:0]   rd_byte,
   output logic               rd_valid,
   output logic               busy,
   output logic               commit_done,
   output logic               fl_we,
   output logic [FADDR_W-1:0] fl_waddr,
   output logic [WORD_W-1:0]  fl_wdata,
   output logic               fl_re,
   output logic [FADDR_W-1:0] fl_raddr,
   input  logic [WORD_W-1:0]  fl_rdata
);

   // Elaboration-time parameter checks.
   generate
      if (!is_pow2(PAGE_BYTES) || PAGE_BYTES < 32 || PAGE_BYTES > 256) begin : g_bad_page
         $error("prog_addr_unit: PAGE_BYTES must be a power of two in 32..256");
      end
      if (OFF_W > REG_W) begin : g_bad_reg
         $error("prog_addr_unit: page offset must fit in the low pointer register");
      end
   endgenerate

   logic [FADDR_W-1:0] word_addr;
   logic [PAGE_W-1:0]  page_num;
   logic [SLOT_W-1:0]  fill_slot;
   logic               byte_sel;
   logic [SLOT_W-1:0]  copy_slot;
   logic               idle;
   logic               take_commit;
   logic               take_fill;
   logic               take_read;

   ptr_decode #(
      .REG_W      (REG_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) dec_i (
      .ptr_hi    (ptr_hi),
      .ptr_lo    (ptr_lo),
      .word_addr (word_addr),
      .page_num  (page_num),
      .slot      (fill_slot),
      .byte_sel  (byte_sel)
   );

   // One command per cycle: commit beats fill, fill beats read; none while busy.
   assign idle        = !busy;
   assign take_commit = idle && cmd_commit;
   assign take_fill   = idle && cmd_fill && !cmd_commit;
   assign take_read   = idle && cmd_read && !cmd_commit && !cmd_fill;

   page_buffer #(
      .WORD_W (WORD_W),
      .SLOTS  (SLOTS)
   ) buf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take_fill),
      .wr_slot (fill_slot),
      .wr_data (fill_data),
      .rd_slot (copy_slot),
      .rd_data (fl_wdata)
   );

   commit_seq #(
      .PAGE_W (PAGE_W),
      .SLOT_W (SLOT_W)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (take_commit),
      .start_page (page_num),
      .busy       (busy),
      .done       (commit_done),
      .fl_we      (fl_we),
      .fl_waddr   (fl_waddr),
      .cur_slot   (copy_slot)
   );

   byte_reader #(
      .REG_W (REG_W)
   ) rd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (take_read),
      .word_addr (word_addr),
      .byte_sel  (byte_sel),
      .fl_re     (fl_re),
      .fl_raddr  (fl_raddr),
      .fl_rdata  (fl_rdata),
      .rd_byte   (rd_byte),
      .rd_valid  (rd_valid)
   );

endmodule

// File: rtl/prog_addr_unit_chk.sv
`timescale 1ns/1ps
module prog_addr_unit_chk #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned PAGE_BYTES = 64,
   localparam int unsigned SLOTS     = PAGE_BYTES / 2,
   localparam int unsigned SLOT_W    = $clog2(PAGE_BYTES) - 1,
   localparam int unsigned FADDR_W   = 2 * REG_W - 1,
   localparam int unsigned CNT_W     = $clog2(SLOTS) + 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               commit_done,
   input logic               fl_we,
   input logic [FADDR_W-1:0] fl_waddr,
   input logic               fl_re,
   input logic               rd_valid
);

   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (busy) begin
         busy_cnt <= busy_cnt + 1'b1;
      end else begin
         busy_cnt <= '0;
      end
   end

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == CNT_W'(SLOTS));

   // R5
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CNT_W'(SLOTS));

   // R6
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done |-> $fell(busy));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_done |=> !commit_done);

   // R7
   no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !fl_re);

   // R2
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_re |=> rd_valid);

   // R2
   valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(fl_re));

   // R4
   write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we && $past(fl_we)) |-> fl_waddr == $past(fl_waddr) + 1'b1);

   // R4
   write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we) |-> fl_waddr[SLOT_W-1:0] == '0);

endmodule

bind prog_addr_unit prog_addr_unit_chk #(
   .REG_W      (REG_W),
   .PAGE_BYTES (PAGE_BYTES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .commit_done (commit_done),
   .fl_we       (fl_we),
   .fl_waddr    (fl_waddr),
   .fl_re       (fl_re),
   .rd_valid    (rd_valid)
);

// File: tb/prog_addr_unit_tb.sv
`timescale 1ns/1ps
module prog_addr_unit_tb_top;

   localparam int SLOTS = 32;
   localparam int MEM_N = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ptr_hi = '0, ptr_lo = '0;
   logic        cmd_fill = 1'b0, cmd_commit = 1'b0, cmd_read = 1'b0;
   logic [15:0] fill_data = '0;
   logic [7:0]  rd_byte;
   logic        rd_valid, busy, commit_done, fl_we, fl_re;
   logic [14:0] fl_waddr, fl_raddr;
   logic [15:0] fl_wdata;
   logic [15:0] fl_rdata = '0;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [15:0] mem     [MEM_N];
   logic [15:0] exp_mem [MEM_N];
   logic [15:0] mbuf    [SLOTS];

   int          wr_cnt = 0;
   int          order_bad = 0;
   logic [14:0] first_addr = '0;
   logic [14:0] prev_addr = '0;

   // Fill vectors: {pointer, data}, walked in order.
   localparam logic [31:0] FILL_VEC [8] = '{
      {16'h0440, 16'hC0DE},   // slot 0
      {16'h0443, 16'hBEEF},   // odd -> slot 1
      {16'h0445, 16'h7A19},   // odd -> slot 2
      {16'h1F0A, 16'h55AA},   // foreign page bits -> slot 5
      {16'h047E, 16'h0F0F},   // slot 31
      {16'h047F, 16'h8001},   // odd -> slot 31 again
      {16'h0452, 16'h3CC3},   // slot 9
      {16'h0461, 16'hA0B1}    // odd -> slot 16
   };

   always #2.5 clk = ~clk;

   prog_addr_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ptr_hi      (ptr_hi),
      .ptr_lo      (ptr_lo),
      .cmd_fill    (cmd_fill),
      .fill_data   (fill_data),
      .cmd_commit  (cmd_commit),
      .cmd_read    (cmd_read),
      .rd_byte     (rd_byte),
      .rd_valid    (rd_valid),
      .busy        (busy),
      .commit_done (commit_done),
      .fl_we       (fl_we),
      .fl_waddr    (fl_waddr),
      .fl_wdata    (fl_wdata),
      .fl_re       (fl_re),
      .fl_raddr    (fl_raddr),
      .fl_rdata    (fl_rdata)
   );

   function automatic logic [15:0] init_word(input int i);
      logic [15:0] w;
      w = 16'(i) * 16'd37;
      return w ^ 16'hC35A;
   endfunction

   // Flash model: synchronous write and read ports, one-cycle read latency.
   always @(posedge clk) begin
      if (fl_we) begin
         mem[fl_waddr[10:0]] <= fl_wdata;
         if (wr_cnt == 0) first_addr = fl_waddr;
         else if (fl_waddr != prev_addr + 15'd1) order_bad++;
         prev_addr = fl_waddr;
         wr_cnt++;
      end
      if (fl_re) fl_rdata <= mem[fl_raddr[10:0]];
   end

   function automatic logic [7:0] pick(input logic [15:0] p);
      logic [15:0] w;
      w = exp_mem[p[11:1]];
      return p[0] ? w[15:8] : w[7:0];
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_ptr(input logic [15:0] p);
      ptr_hi = p[15:8];
      ptr_lo = p[7:0];
   endtask

   task automatic do_fill(input logic [15:0] p, input logic [15:0] d);
      @(negedge clk);
      set_ptr(p); cmd_fill = 1'b1; fill_data = d;
      @(negedge clk);
      cmd_fill = 1'b0;
      mbuf[p[5:1]] = d;
   endtask

   task automatic do_read(input logic [15:0] p, input string req);
      @(negedge clk);
      set_ptr(p); cmd_read = 1'b1;
      @(negedge clk);
      cmd_read = 1'b0;
      check(req, $sformatf("rd_valid ptr=%0h", p), 32'(rd_valid), 32'd1);
      check(req, $sformatf("rd_byte ptr=%0h", p), 32'(rd_byte), 32'(pick(p)));
   endtask

   task automatic do_commit(input logic [15:0] p, input bit with_fill,
                            input logic [15:0] fdata, input bit with_read,
                            input bit inject, input string req);
      int cnt;
      @(negedge clk);
      set_ptr(p); cmd_commit = 1'b1; cmd_fill = with_fill;
      fill_data = fdata; cmd_read = with_read;
      wr_cnt = 0; order_bad = 0;
      @(negedge clk);
      cmd_commit = 1'b0; cmd_fill = 1'b0; cmd_read = 1'b0;
      for (int s = 0; s < SLOTS; s++) exp_mem[{p[11:6], 5'(s)}] = mbuf[s];
      check("R5", "busy after commit", 32'(busy), 32'd1);
      check(req, "no read strobe after commit cycle", 32'(rd_valid), 32'd0);
      cnt = 1;
      if (inject) begin
         set_ptr(16'h0080); cmd_fill = 1'b1; fill_data = 16'hDEAD;
         cmd_read = 1'b1; cmd_commit = 1'b1;
         @(negedge clk);
         cmd_fill = 1'b0; cmd_read = 1'b0; cmd_commit = 1'b0;
         check("R7", "read ignored while busy", 32'(rd_valid), 32'd0);
         if (busy) cnt++;
      end
      while (1) begin
         @(negedge clk);
         if (!busy || cnt > 1000) break;
         cnt++;
      end
      check("R5", "busy length", 32'(cnt), 32'(SLOTS));
      check("R6", "done with busy low", 32'(commit_done), 32'd1);
      check("R4", "write count", 32'(wr_cnt), 32'(SLOTS));
      check("R4", "first write address", 32'(first_addr), 32'({p[15:6], 5'd0}));
      check("R4", "write order", 32'(order_bad), 32'd0);
      @(negedge clk);
      check("R6", "done is one cycle", 32'(commit_done), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MEM_N; i++) begin
         mem[i] = init_word(i);
         exp_mem[i] = init_word(i);
      end
      for (int s = 0; s < SLOTS; s++) mbuf[s] = 16'hFFFF;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", 32'(busy), 32'd0);
      check("R1", "done in reset", 32'(commit_done), 32'd0);
      check("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
      check("R1", "fl_we in reset", 32'(fl_we), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", 32'(busy), 32'd0);
      check("R1", "fl_re after reset", 32'(fl_re), 32'd0);
      check("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);

      // R2: word 2 is pointer 4; bit 0 picks the byte
      do_read(16'h0004, "R2");
      do_read(16'h0005, "R2");
      do_read(16'h0441, "R2");

      // R3 / R4: table-driven fill, commit with offset bits set, read back
      for (int v = 0; v < 8; v++) do_fill(FILL_VEC[v][31:16], FILL_VEC[v][15:0]);
      do_commit(16'h047E, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
      for (int b = 0; b < 64; b++) do_read(16'h0440 + 16'(b), "R3");

      // R8: fill beats read in the same idle cycle
      @(negedge clk);
      set_ptr(16'h0448); cmd_fill = 1'b1; fill_data = 16'h4D4D; cmd_read = 1'b1;
      @(negedge clk);
      cmd_fill = 1'b0; cmd_read = 1'b0;
      mbuf[4] = 16'h4D4D;
      check("R8", "read loses to fill", 32'(rd_valid), 32'd0);

      // R8: commit beats fill and read (page 9)
      do_commit(16'h0242, 1'b1, 16'h1234, 1'b1, 1'b0, "R8");
      do_read(16'h0242, "R8");
      do_read(16'h0243, "R8");
      do_read(16'h0248, "R8");

      // R7 / R9: commands during a page copy to page 5 are ignored
      do_commit(16'h0140, 1'b0, 16'h0, 1'b0, 1'b1, "R7");
      do_read(16'h0080, "R7");
      do_read(16'h0081, "R7");
      do_read(16'h0140, "R7");
      do_read(16'h017F, "R9");
      do_read(16'h0146, "R9");
      check("R9", "untouched slot model is erased", 32'(exp_mem[11'h0A3]), 32'hFFFF);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule